// File: doc/BRIEF.md
# Counted-Enable Interrupt Source Aggregator

This block watches a fixed set of level-sensitive interrupt sources and merges them into one interrupt request for a processor. Several independent enable bits can gate a source, for example a mask bit, a priority field and a group bit. The block therefore does not hold a single enable flag per source. It keeps a count of granted enables and compares it with a required count that is fixed when the design is built. A source is pending only while its line is asserted and its granted count equals its required count. Each cycle, one strobe raises a source's granted count and a separate strobe lowers it. Register decoding elsewhere in the chip drives these strobes when a software write changes an enable bit.

A running tally holds the number of pending sources, and the processor request line is driven from that tally. The processor, or an acknowledge path, can also issue a vector query with a 4-bit interrupt mask. One cycle later the block answers with the 16-bit vector code of the lowest-numbered pending source. When no source is pending, or when the mask is all ones, it answers with "nothing valid". It does not arbitrate priority between sources.

Each source runs a small state machine with three states:
- `SRC_IDLE`: the line is low.
- `SRC_HELD`: the line is high but the enables are incomplete.
- `SRC_PEND`: the source is pending.

The source transitions are:
- line rises: IDLE→HELD, or IDLE→PEND when the enables are complete;
- enables become complete: HELD→PEND;
- enables become incomplete: PEND→HELD;
- line falls: HELD→IDLE or PEND→IDLE.

The request line has its own two-state machine. It moves from `IRQ_QUIET` to `IRQ_ACTIVE` when the tally leaves zero, and from `IRQ_ACTIVE` to `IRQ_QUIET` when the tally returns to zero.

Top module: `cei_irq_agg`

## Requirements
- R1: After reset the request line is low, every granted count is zero, no source is pending, `rsp_stb` is low, and a query returns `rsp_valid`=0 with `rsp_vec`=0.
- R2: Source i requires (i mod REQ_MAX)+1 granted enables. It is pending only while its line is high and its granted count equals that number exactly. A count above the required number does not make the source pending.
- R3: A source's asserted state follows its line. A rising line sets it and a falling line clears it. Holding the line at the same level has no effect.
- R4: In one cycle, `en_inc[i]` alone adds one to the granted count of source i and `en_dec[i]` alone subtracts one. Both strobes together leave the count unchanged. The count holds at zero instead of wrapping below, and holds at 2^CNT_W-1 instead of wrapping above.
- R5: `cpu_irq` is high exactly when at least one source is pending. It reflects input changes from the edge at which they are sampled, so they are visible in the following cycle.
- R6: A query with `qry_mask`=4'hF returns `rsp_valid`=0 and `rsp_vec`=0, whatever is pending.
- R7: A query pulses `rsp_stb` in the next cycle. If the mask is not 4'hF and a source is pending, `rsp_valid` is 1 and `rsp_vec` equals VEC_BASE + i*VEC_STEP, where i is the lowest-numbered pending source. The defaults give 16'h0400 + 16'h0020*i.
- R8: A query made while no source is pending returns `rsp_valid`=0 and `rsp_vec`=0.
- R9: The pending tally stays correct when several sources change in the same cycle, including one entering and another leaving pending. The request line stays high until the last pending source leaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl | input | NSRC | Interrupt line level, one per source |
| en_inc | input | NSRC | Grant one more enable to a source |
| en_dec | input | NSRC | Withdraw one enable from a source |
| qry_req | input | 1 | Vector query request |
| qry_mask | input | 4 | Interrupt mask given with the query |
| cpu_irq | output | 1 | Processor interrupt request |
| rsp_stb | output | 1 | Query response strobe, one cycle after `qry_req` |
| rsp_valid | output | 1 | Response holds a pending source's vector |
| rsp_vec | output | VEC_W | Vector code of the chosen source, zero when not valid |

## Verification
The gating rule is exercised with sources whose required counts are one, two and three. Counts are walked below the target, onto it and above it, which separates an equality test from a greater-or-equal test. Lowest-index selection is checked with pairs of pending sources whose lower member is dropped and brought back. This separates a priority encoder from one that scans in the wrong direction or latches a stale choice. Same-cycle strobe pairs, underflow and overflow walks, and one source entering while another leaves in the same cycle are each chosen so that a wrapping counter, a miscounted tally or a missing cancellation leads to a different pending result than the correct design.

// File: rtl/cei_pkg.sv
package cei_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_HELD = 2'd1,
        SRC_PEND = 2'd2
    } src_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    localparam int unsigned MASK_W   = 4;
    localparam logic [MASK_W-1:0] MASK_ALL = 4'hF;

endpackage

// File: rtl/cei_src_fsm.sv
module cei_src_fsm
    import cei_pkg::*;
#(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned REQ   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic inc,
    input  logic dec,
    output logic pend,
    output logic enter_pend,
    output logic leave_pend
);
    localparam logic [CNT_W-1:0] REQ_C   = CNT_W'(REQ);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    src_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic           en_full;

    // granted-enable counter: cancel on both strobes, saturate at the ends
    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != CNT_TOP) begin
            cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign en_full = (cnt_d == REQ_C);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: begin
                if (lvl) state_d = en_full ? SRC_PEND : SRC_HELD;
            end
            SRC_HELD: begin
                if (!lvl)        state_d = SRC_IDLE;
                else if (en_full) state_d = SRC_PEND;
            end
            SRC_PEND: begin
                if (!lvl)         state_d = SRC_IDLE;
                else if (!en_full) state_d = SRC_HELD;
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        pend       = (state_q == SRC_PEND);
        enter_pend = (state_d == SRC_PEND) && (state_q != SRC_PEND);
        leave_pend = (state_d != SRC_PEND) && (state_q == SRC_PEND);
    end

endmodule

// File: rtl/cei_pend_tally.sv
module cei_pend_tally
    import cei_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] enter,
    input  logic [NSRC-1:0] leave,
    output logic            cpu_irq
);
    localparam int unsigned TW = $clog2(NSRC + 1);

    logic [TW-1:0] tally_q, tally_d;
    logic [TW:0]   n_in, n_out, sum;
    irq_state_e    irq_q, irq_d;

    always_comb begin
        n_in  = '0;
        n_out = '0;
        for (int i = 0; i < NSRC; i++) begin
            n_in  = n_in  + (TW+1)'(enter[i]);
            n_out = n_out + (TW+1)'(leave[i]);
        end
        sum     = {1'b0, tally_q} + n_in - n_out;
        tally_d = sum[TW-1:0];
    end

    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_QUIET:  if (tally_d != '0) irq_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (tally_d == '0) irq_d = IRQ_QUIET;
            default:    irq_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally_q <= '0;
            irq_q   <= IRQ_QUIET;
        end else begin
            tally_q <= tally_d;
            irq_q   <= irq_d;
        end
    end

    always_comb cpu_irq = (irq_q == IRQ_ACTIVE);

endmodule

// File: rtl/cei_lowest_pick.sv
module cei_lowest_pick #(
    parameter int unsigned NSRC = 8,
    localparam int unsigned IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] pend,
    output logic            found,
    output logic [IW-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cei_irq_agg.sv
module cei_irq_agg
    import cei_pkg::*;
#(
    parameter int unsigned NSRC     = 8,
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned REQ_MAX  = 3,
    parameter int unsigned VEC_W    = 16,
    parameter int unsigned VEC_BASE = 32'h0400,
    parameter int unsigned VEC_STEP = 32'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_lvl,
    input  logic [NSRC-1:0]   en_inc,
    input  logic [NSRC-1:0]   en_dec,
    input  logic              qry_req,
    input  logic [3:0]        qry_mask,
    output logic              cpu_irq,
    output logic              rsp_stb,
    output logic              rsp_valid,
    output logic [VEC_W-1:0]  rsp_vec
);
    localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] pend, enter, leave;
    logic            found;
    logic [IW-1:0]   idx;
    logic [VEC_W-1:0] pick_vec;
    logic            hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        cei_src_fsm #(
            .CNT_W (CNT_W),
            .REQ   ((g % REQ_MAX) + 1)
        ) src_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl        (irq_lvl[g]),
            .inc        (en_inc[g]),
            .dec        (en_dec[g]),
            .pend       (pend[g]),
            .enter_pend (enter[g]),
            .leave_pend (leave[g])
        );
    end

    cei_pend_tally #(.NSRC(NSRC)) tally_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enter   (enter),
        .leave   (leave),
        .cpu_irq (cpu_irq)
    );

    cei_lowest_pick #(.NSRC(NSRC)) pick_i (
        .pend  (pend),
        .found (found),
        .idx   (idx)
    );

    always_comb begin
        pick_vec = VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);
        hit      = found && (qry_mask != MASK_ALL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_stb   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_vec   <= '0;
        end else begin
            rsp_stb   <= qry_req;
            rsp_valid <= qry_req && hit;
            rsp_vec   <= (qry_req && hit) ? pick_vec : '0;
        end
    end

endmodule

// File: rtl/cei_irq_agg_chk.sv
module cei_irq_agg_chk #(
    parameter int unsigned NSRC  = 8,
    parameter int unsigned VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  irq_lvl,
    input logic [NSRC-1:0]  en_inc,
    input logic [NSRC-1:0]  en_dec,
    input logic             qry_req,
    input logic [3:0]       qry_mask,
    input logic             cpu_irq,
    input logic             rsp_stb,
    input logic             rsp_valid,
    input logic [VEC_W-1:0] rsp_vec
);
    p_stb_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        qry_req |=> rsp_stb);

    p_no_stb_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_req |=> !rsp_stb);

    p_hit_when_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_req && qry_mask != 4'hF && cpu_irq) |=> rsp_valid);

    p_mask_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_req && qry_mask == 4'hF) |=> (rsp_stb && !rsp_valid));

    p_none_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_req && !cpu_irq) |=> !rsp_valid);

    p_vec_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_vec == '0));

    p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(irq_lvl) && en_inc == '0 && en_dec == '0)
            |=> $stable(cpu_irq));
endmodule

bind cei_irq_agg cei_irq_agg_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lvl   (irq_lvl),
    .en_inc    (en_inc),
    .en_dec    (en_dec),
    .qry_req   (qry_req),
    .qry_mask  (qry_mask),
    .cpu_irq   (cpu_irq),
    .rsp_stb   (rsp_stb),
    .rsp_valid (rsp_valid),
    .rsp_vec   (rsp_vec)
);

// File: tb/cei_irq_agg_tb_top.sv
module cei_irq_agg_tb_top;
    localparam int CLK_P = 10;
    localparam int NS    = 8;
    localparam int WDOG  = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_lvl = '0, en_inc = '0, en_dec = '0;
    logic          qry_req = 1'b0;
    logic [3:0]    qry_mask = 4'h0;
    logic          cpu_irq, rsp_stb, rsp_valid;
    logic [15:0]   rsp_vec;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    cei_irq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .en_inc(en_inc),
        .en_dec(en_dec), .qry_req(qry_req), .qry_mask(qry_mask),
        .cpu_irq(cpu_irq), .rsp_stb(rsp_stb), .rsp_valid(rsp_valid),
        .rsp_vec(rsp_vec)
    );

    // {lvl, inc, dec, exp_irq, exp_valid, exp_vec}; query made with mask 0
    localparam int NROW = 14;
    localparam logic [41:0] TBL [NROW] = '{
        {8'h01, 8'h01, 8'h00, 1'b1, 1'b1, 16'h0400},
        {8'h03, 8'h02, 8'h00, 1'b1, 1'b1, 16'h0400},
        {8'h03, 8'h02, 8'h00, 1'b1, 1'b1, 16'h0400},
        {8'h02, 8'h00, 8'h00, 1'b1, 1'b1, 16'h0420},
        {8'h02, 8'h02, 8'h00, 1'b0, 1'b0, 16'h0000},
        {8'h02, 8'h00, 8'h02, 1'b1, 1'b1, 16'h0420},
        {8'h0A, 8'h08, 8'h00, 1'b1, 1'b1, 16'h0420},
        {8'h08, 8'h00, 8'h00, 1'b1, 1'b1, 16'h0460},
        {8'h08, 8'h02, 8'h02, 1'b1, 1'b1, 16'h0460},
        {8'h0A, 8'h00, 8'h00, 1'b1, 1'b1, 16'h0420},
        {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000},
        {8'h80, 8'h80, 8'h00, 1'b0, 1'b0, 16'h0000},
        {8'h80, 8'h80, 8'h00, 1'b1, 1'b1, 16'h04E0},
        {8'h00, 8'h00, 8'h80, 1'b0, 1'b0, 16'h0000}
    };

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, WDOG);
            summary();
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [NS-1:0] l, logic [NS-1:0] i, logic [NS-1:0] d);
        irq_lvl = l; en_inc = i; en_dec = d;
        cyc();
        en_inc = '0; en_dec = '0;
    endtask

    task automatic query(string tag, logic [3:0] m, logic ev, logic [15:0] evec);
        qry_req = 1'b1; qry_mask = m;
        cyc();
        qry_req = 1'b0; qry_mask = 4'h0;
        check({tag, " stb"}, 32'(rsp_stb), 32'd1);
        check({tag, " valid"}, 32'(rsp_valid), 32'(ev));
        check({tag, " vec"}, 32'(rsp_vec), 32'(evec));
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        check("R1 irq", 32'(cpu_irq), 32'd0);
        check("R1 stb", 32'(rsp_stb), 32'd0);
        query("R1 query", 4'h0, 1'b0, 16'h0);

        // table walk: R2, R3, R4, R5, R7
        for (int r = 0; r < NROW; r++) begin
            drive(TBL[r][41:34], TBL[r][33:26], TBL[r][25:18]);
            check($sformatf("R5 row%0d irq", r), 32'(cpu_irq), 32'(TBL[r][17]));
            query($sformatf("R2/R7 row%0d", r), 4'h0, TBL[r][16], TBL[r][15:0]);
        end

        // R6: all-ones mask masks everything; other masks do not filter
        drive(8'h01, 8'h00, 8'h00);
        check("R5 irq src0", 32'(cpu_irq), 32'd1);
        query("R6 mask F", 4'hF, 1'b0, 16'h0);
        query("R7 mask E", 4'hE, 1'b1, 16'h0400);

        // R9: several sources changing in one cycle
        drive(8'h09, 8'h00, 8'h00);
        check("R9 two pend irq", 32'(cpu_irq), 32'd1);
        drive(8'h08, 8'h00, 8'h00);
        check("R9 one left irq", 32'(cpu_irq), 32'd1);
        query("R9 src3", 4'h0, 1'b1, 16'h0460);
        drive(8'h01, 8'h00, 8'h00);
        check("R9 swap irq", 32'(cpu_irq), 32'd1);
        query("R9 swap", 4'h0, 1'b1, 16'h0400);
        drive(8'h00, 8'h00, 8'h00);
        check("R9 all gone irq", 32'(cpu_irq), 32'd0);
        query("R8 none", 4'h0, 1'b0, 16'h0);

        // R4 floor at zero: src4 needs 2
        drive(8'h00, 8'h00, 8'h10);
        drive(8'h00, 8'h10, 8'h00);
        drive(8'h00, 8'h10, 8'h00);
        drive(8'h10, 8'h00, 8'h00);
        check("R4 floor irq", 32'(cpu_irq), 32'd1);
        query("R4 floor", 4'h0, 1'b1, 16'h0480);
        drive(8'h00, 8'h00, 8'h00);

        // R4 ceiling: src2 needs 3, push 9 up then 4 down
        for (int k = 0; k < 9; k++) drive(8'h00, 8'h04, 8'h00);
        for (int k = 0; k < 4; k++) drive(8'h00, 8'h00, 8'h04);
        drive(8'h04, 8'h00, 8'h00);
        check("R4 ceil irq", 32'(cpu_irq), 32'd1);
        query("R4 ceil", 4'h0, 1'b1, 16'h0440);

        // R3: holding the level changes nothing
        drive(8'h04, 8'h00, 8'h00);
        drive(8'h04, 8'h00, 8'h00);
        check("R3 hold irq", 32'(cpu_irq), 32'd1);
        query("R3 hold", 4'h0, 1'b1, 16'h0440);
        drive(8'h00, 8'h00, 8'h00);
        check("R3 fall irq", 32'(cpu_irq), 32'd0);

        // R7: no strobe without a query
        cyc();
        check("R7 idle stb", 32'(rsp_stb), 32'd0);

        summary();
    end
endmodule